// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master that reaches external PHYs over the two-wire MDC/MDIO interface using Clause 45 indirect access. Software sees four 32-bit registers on a simple write-strobe port with a combinational read path. It sets up the port and device addresses in the control register. It then sends an address frame by writing the address register. After that, it either writes the data register to send a write frame, or sets the read-start bit in control to send a read frame. A read frame returns a 16-bit value into the data register.

MDC is made from the system clock with a programmable half-period count. While a frame is in flight, MDIO changes only while MDC is low. For a read, the driver lets go of the line from the first turnaround bit to the end of the frame, so the PHY can answer. If the PHY does not pull the second turnaround bit low, the read-error flag is set. In that case the line's pull-up makes the captured value all ones.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and the MDIO output enable is low.
- R2: Status bits 15:8 hold a divide field D. While a frame runs, MDC has a period of 2*(D+1) system clocks, so D=0 gives 2. MDC rests low when no frame runs.
- R3: Every frame is sent MSB first: 32 ones of preamble (dropped when control bit 10 is set), start 00, a 2-bit opcode, port address (control 9:5), device address (control 4:0), 2 turnaround bits, then 16 payload bits. MDIO never changes while MDC is high.
- R4: Writing byte offset 0x3C stores the low 16 bits and sends an address frame (opcode 00) carrying them. Status bit 0 reads 1 until that frame ends.
- R5: Writing offset 0x38 sends a write frame (opcode 01, turnaround 10) carrying the low 16 bits. Data bit 31 and status bit 0 read 1 until the frame ends.
- R6: Writing offset 0x34 with bit 15 set sends a read frame (opcode 11). The output enable is low from the first turnaround bit to the frame end. The bits sampled on rising MDC land in data bits 15:0, and data bit 31 then clears.
- R7: If the second turnaround bit of a read is sampled high, status bit 1 sets. It clears when the next read frame starts.
- R8: A read started with control bit 14 also set uses opcode 10. The address register (offset 0x3C) reads one higher once the frame ends.
- R9: Any register write while status bit 0 is 1 has no effect: no register changes and no frame is sent.
- R10: An address frame leaves data bit 31 at 0.
- R11: Control bit 15 always reads 0. Control bits 14, 11, 10 and 9:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mdc | output | 1 | Management clock to PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
A wrong bit index or a stale frame register shows up at once as a wrong bit on the line. The bench decodes every rising MDC edge against the frame it expects, so the faulty bit is caught within the frame where it occurs. A wrong divider count shows within the first two MDC rises of a frame. A turnaround or capture fault shows in the data register and the error flag as soon as the read frame ends. A busy flag that does not clear, or that clears early, shows up as a hang caught by the watchdog, or as a frame that was dropped or arrived unexpectedly.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RDINC = 2'b10,
    OP_READ  = 2'b11
  } mdio_op_e;

  localparam logic [7:0] OFF_STAT = 8'h30;
  localparam logic [7:0] OFF_CTRL = 8'h34;
  localparam logic [7:0] OFF_DATA = 8'h38;
  localparam logic [7:0] OFF_ADDR = 8'h3C;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_d, term;

  always_comb begin
    term    = run && (cnt_q == half_div);
    rise_ev = term && !mdc;
    fall_ev = term && mdc;
    cnt_d   = cnt_q;
    mdc_d   = mdc;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc   <= mdc_d;
    end
  end

  // R2: clock rests low when no frame runs
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R2: clock only moves on a terminal count
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rise_ev && !fall_ev) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_c45_pkg::*;
#(
  parameter int FIELD_W = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  mdio_op_e           op,
  input  logic [FIELD_W-1:0] port,
  input  logic [FIELD_W-1:0] dev,
  input  logic               pre_dis,
  input  logic [DATA_W-1:0]  payload,
  input  logic               rise_ev,
  input  logic               fall_ev,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic               rd_err,
  output logic [DATA_W-1:0]  rd_data,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam int BODY_LEN  = 6 + 2 * FIELD_W + DATA_W;
  localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_BODY = IDX_W'(BODY_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_TA1  = IDX_W'(DATA_W + 1);

  logic                 busy_q, busy_d, rd_q, rd_d, err_q, err_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] frm_q, frm_d;
  logic [DATA_W-1:0]    sh_q, sh_d;
  logic                 is_rd;

  assign is_rd = op[1];

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    err_d  = err_q;
    idx_d  = idx_q;
    frm_d  = frm_q;
    sh_d   = sh_q;
    done   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = is_rd;
      idx_d  = pre_dis ? IDX_BODY : IDX_FULL;
      frm_d  = {{PRE_LEN{1'b1}}, 2'b00, 2'(op), port, dev,
                (is_rd ? 2'b11 : 2'b10), payload};
      if (is_rd) err_d = 1'b0;
    end else if (busy_q) begin
      if (rise_ev && rd_q) begin
        if (idx_q == IDX_TA2 && mdio_i) err_d = 1'b1;
        if (idx_q < IDX_TA2) sh_d = {sh_q[DATA_W-2:0], mdio_i};
      end
      if (fall_ev) begin
        if (idx_q == '0) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      frm_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      err_q  <= err_d;
      idx_q  <= idx_d;
      frm_q  <= frm_d;
      sh_q   <= sh_d;
    end
  end

  assign busy    = busy_q;
  assign rd_err  = err_q;
  assign rd_data = sh_q;
  assign mdio_o  = frm_q[idx_q];
  assign mdio_oe = busy_q && !(rd_q && idx_q <= IDX_TA1);

  // R7: the error flag only rises during a read frame
  a_r7_err_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(busy_q) && $past(rd_q)));
  // R6: a captured bit only moves during a read frame
  a_r6_capture_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_q) |-> $past(rd_q));
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int FIELD_W = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DEV_LO  = 0;
  localparam int PORT_LO = FIELD_W;
  localparam int PRE_BIT = 10;
  localparam int SCN_BIT = 11;
  localparam int INC_BIT = 14;
  localparam int RD_BIT  = 15;

  logic [DIV_W-1:0]   div_q, div_d;
  logic [FIELD_W-1:0] dev_q, dev_d, port_q, port_d;
  logic               pre_q, pre_d, scn_q, scn_d, inc_q, inc_d, txn_q, txn_d;
  logic [DATA_W-1:0]  addr_q, addr_d, data_q, data_d;
  mdio_op_e           op_q, op_d;

  logic               busy, done, rd_err, rise_ev, fall_ev, wr_ok;
  logic [DATA_W-1:0]  rd_data;
  logic               st_go;
  logic [FIELD_W-1:0] st_port, st_dev;
  logic               st_pre;
  logic [DATA_W-1:0]  st_pay;

  assign wr_ok = reg_we && !busy;

  always_comb begin
    div_d  = div_q;  dev_d  = dev_q;  port_d = port_q;
    pre_d  = pre_q;  scn_d  = scn_q;  inc_d  = inc_q;
    txn_d  = txn_q;  addr_d = addr_q; data_d = data_q;
    op_d   = op_q;
    st_go  = 1'b0;   st_port = port_q; st_dev = dev_q;
    st_pre = pre_q;  st_pay  = '1;
    if (wr_ok) begin
      unique case (reg_addr)
        OFF_STAT: div_d = reg_wdata[8 +: DIV_W];
        OFF_CTRL: begin
          dev_d  = reg_wdata[DEV_LO +: FIELD_W];
          port_d = reg_wdata[PORT_LO +: FIELD_W];
          pre_d  = reg_wdata[PRE_BIT];
          scn_d  = reg_wdata[SCN_BIT];
          inc_d  = reg_wdata[INC_BIT];
          if (reg_wdata[RD_BIT]) begin
            st_go   = 1'b1;
            op_d    = reg_wdata[INC_BIT] ? OP_RDINC : OP_READ;
            txn_d   = 1'b1;
            st_port = port_d;
            st_dev  = dev_d;
            st_pre  = pre_d;
          end
        end
        OFF_DATA: begin
          st_go  = 1'b1;
          op_d   = OP_WRITE;
          txn_d  = 1'b1;
          st_pay = reg_wdata[DATA_W-1:0];
        end
        OFF_ADDR: begin
          st_go  = 1'b1;
          op_d   = OP_ADDR;
          addr_d = reg_wdata[DATA_W-1:0];
          st_pay = reg_wdata[DATA_W-1:0];
        end
        default: ;
      endcase
    end
    if (done) begin
      txn_d = 1'b0;
      if (op_q[1]) data_d = rd_data;
      if (op_q == OP_RDINC) addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; dev_q <= '0; port_q <= '0; pre_q <= 1'b0; scn_q <= 1'b0;
      inc_q <= 1'b0; txn_q <= 1'b0; addr_q <= '0; data_q <= '0; op_q <= OP_ADDR;
    end else begin
      div_q <= div_d; dev_q <= dev_d; port_q <= port_d; pre_q <= pre_d; scn_q <= scn_d;
      inc_q <= inc_d; txn_q <= txn_d; addr_q <= addr_d; data_q <= data_d; op_q <= op_d;
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(div_q),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_eng #(.FIELD_W(FIELD_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(st_go), .op(op_d), .port(st_port), .dev(st_dev),
    .pre_dis(st_pre), .payload(st_pay), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .mdio_i(mdio_i), .busy(busy), .done(done), .rd_err(rd_err), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_STAT: begin
        reg_rdata[8 +: DIV_W] = div_q;
        reg_rdata[1]          = rd_err;
        reg_rdata[0]          = busy;
      end
      OFF_CTRL: begin
        reg_rdata[DEV_LO +: FIELD_W]  = dev_q;
        reg_rdata[PORT_LO +: FIELD_W] = port_q;
        reg_rdata[PRE_BIT]            = pre_q;
        reg_rdata[SCN_BIT]            = scn_q;
        reg_rdata[INC_BIT]            = inc_q;
      end
      OFF_DATA: begin
        reg_rdata[31]         = txn_q;
        reg_rdata[DATA_W-1:0] = data_q;
      end
      OFF_ADDR: reg_rdata[DATA_W-1:0] = addr_q;
      default: ;
    endcase
  end

  // R9: writes during a frame leave the registers alone
  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy && !done) |=> ($stable(div_q) && $stable(dev_q) && $stable(port_q)
                                   && $stable(addr_q) && $stable(data_q)));
  // R3: line value never moves while the management clock is high
  a_r3_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));
  // R10: an address frame never raises the transaction flag
  a_r10_addr_no_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_ADDR) |-> !txn_q);
endmodule

// File: tb/mdio_c45_master_tb_top.sv
module mdio_c45_master_tb_top;
  logic        clk, rst_n, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_ln;
  logic        phy_en, phy_v;
  int          n_tests, n_fail, cyc;
  bit          finished;

  typedef struct {
    logic [63:0] bits;
    int          len;
    bit          rd;
    bit          resp_en;
    logic [15:0] resp;
    int          period;
  } item_t;
  item_t exp_q[$];

  assign mdio_ln = mdio_oe ? mdio_o : (phy_en ? phy_v : 1'b1);

  mdio_c45_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_ln)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    rd(8'h30, s);
    while (s[0]) begin
      @(negedge clk);
      rd(8'h30, s);
    end
    @(negedge clk);
  endtask

  function automatic item_t mk(input bit pre_dis, input logic [1:0] op, input logic [4:0] port,
                               input logic [4:0] dev, input logic [1:0] ta, input logic [15:0] pay,
                               input bit rdf, input bit resp_en, input logic [15:0] resp, input int d);
    item_t it;
    it.bits    = {32'hFFFF_FFFF, 2'b00, op, port, dev, ta, pay};
    it.len     = pre_dis ? 32 : 64;
    it.rd      = rdf;
    it.resp_en = resp_en;
    it.resp    = resp;
    it.period  = 2 * (d + 1);
    return it;
  endfunction

  // monitor and PHY model, working on the falling system clock edge
  item_t       cur;
  bit          active, prev_mdc;
  int          bcnt, last_rise;
  logic [63:0] cap;
  initial begin
    active = 0; prev_mdc = 0; bcnt = 0; phy_en = 0; phy_v = 1; cap = '0; last_rise = 0;
  end
  always @(negedge clk) begin
    if (rst_n && mdc && !prev_mdc) begin
      if (!active) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected frame", 64'd1, 64'd0);
        end else begin
          cur = exp_q.pop_front();
          active = 1; bcnt = 0; cap = '0;
        end
      end
      if (active) begin
        if (bcnt == 1)
          chk(cyc - last_rise == cur.period, "R2 mdc period", 64'(cyc - last_rise), 64'(cur.period));
        last_rise = cyc;
        if (cur.rd && bcnt >= cur.len - 18 && mdio_oe)
          chk(1'b0, "R6 driver not released", 64'd1, 64'd0);
        cap[cur.len - 1 - bcnt] = mdio_ln;
        bcnt++;
        if (bcnt == cur.len) begin
          chk(cap == (cur.bits & ((64'd1 << cur.len) - 64'd1)) || cur.len == 64 && cap == cur.bits,
              "R3 frame bits", cap, cur.bits);
          active = 0;
        end
      end
    end else if (rst_n && !mdc && prev_mdc) begin
      if (!active) phy_en = 0;
      else if (cur.rd && cur.resp_en) begin
        if (bcnt == cur.len - 17) begin phy_en = 1; phy_v = 0; end
        else if (bcnt > cur.len - 17) phy_v = cur.resp[cur.len - 1 - bcnt];
      end
    end
    prev_mdc = mdc;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    n_tests = 0; n_fail = 0; cyc = 0; finished = 0;
    rst_n = 0; reg_we = 0; reg_addr = 8'h30; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h30, v); chk(v == 0, "R1 status reset", 64'(v), 64'd0);
    rd(8'h34, v); chk(v == 0, "R1 control reset", 64'(v), 64'd0);
    rd(8'h38, v); chk(v == 0, "R1 data reset", 64'(v), 64'd0);
    rd(8'h3C, v); chk(v == 0, "R1 address reset", 64'(v), 64'd0);
    chk(!mdc && !mdio_oe, "R1 mdc and oe low", {62'd0, mdc, mdio_oe}, 64'd0);

    // R11 control readback, read bit not held
    wr(8'h30, 32'h0000_0200);
    wr(8'h34, 32'h0000_08A3);
    rd(8'h34, v); chk(v == 32'h0000_08A3, "R11 control readback", 64'(v), 64'h8A3);

    // R4 address frame, port 5 dev 3, divider 2
    exp_q.push_back(mk(0, 2'b00, 5'd5, 5'd3, 2'b10, 16'h1234, 0, 0, 16'h0, 2));
    wr(8'h3C, 32'h0000_1234);
    rd(8'h30, v); chk(v[0] == 1, "R4 bus busy during address frame", 64'(v[0]), 64'd1);
    rd(8'h38, v); chk(v[31] == 0, "R10 no transaction flag on address frame", 64'(v[31]), 64'd0);
    // R9 write while busy is dropped
    wr(8'h3C, 32'h0000_5555);
    wr(8'h30, 32'h0000_0700);
    wait_idle();
    rd(8'h3C, v); chk(v == 32'h1234, "R9 address kept after busy write", 64'(v), 64'h1234);
    rd(8'h30, v); chk(v[15:8] == 8'h02, "R9 divider kept after busy write", 64'(v[15:8]), 64'h2);

    // R5 write frame, no preamble, divider 0
    wr(8'h30, 32'h0000_0000);
    wr(8'h34, 32'h0000_0403);
    exp_q.push_back(mk(1, 2'b01, 5'd0, 5'd3, 2'b10, 16'hBEEF, 0, 0, 16'h0, 0));
    wr(8'h38, 32'h0000_BEEF);
    rd(8'h38, v); chk(v[31] == 1, "R5 transaction flag set", 64'(v[31]), 64'd1);
    rd(8'h30, v); chk(v[0] == 1, "R5 bus busy set", 64'(v[0]), 64'd1);
    wait_idle();
    rd(8'h38, v); chk(v[31] == 0, "R5 transaction flag clear", 64'(v[31]), 64'd0);

    // R6 read with answering PHY, divider 1
    wr(8'h30, 32'h0000_0100);
    exp_q.push_back(mk(0, 2'b11, 5'd7, 5'd1, 2'b10, 16'hA5C3, 1, 1, 16'hA5C3, 1));
    wr(8'h34, 32'h0000_80E1);
    rd(8'h34, v); chk(v[15] == 0, "R11 read bit reads zero", 64'(v[15]), 64'd0);
    wait_idle();
    rd(8'h38, v); chk(v == 32'h0000_A5C3, "R6 read value", 64'(v), 64'hA5C3);
    rd(8'h30, v); chk(v[1] == 0, "R7 no error on answered read", 64'(v[1]), 64'd0);

    // R7 read with no PHY: turnaround stays high
    exp_q.push_back(mk(0, 2'b11, 5'd9, 5'd2, 2'b11, 16'hFFFF, 1, 0, 16'h0, 1));
    wr(8'h34, 32'h0000_8122);
    wait_idle();
    rd(8'h30, v); chk(v[1] == 1, "R7 read error set", 64'(v[1]), 64'd1);
    rd(8'h38, v); chk(v == 32'h0000_FFFF, "R7 data all ones", 64'(v), 64'hFFFF);

    // R8 post-increment read
    exp_q.push_back(mk(0, 2'b10, 5'd9, 5'd2, 2'b10, 16'h0F0F, 1, 1, 16'h0F0F, 1));
    wr(8'h34, 32'h0000_C122);
    wait_idle();
    rd(8'h3C, v); chk(v == 32'h1235, "R8 address incremented", 64'(v), 64'h1235);
    rd(8'h38, v); chk(v == 32'h0000_0F0F, "R8 read value", 64'(v), 64'hF0F);
    rd(8'h30, v); chk(v[1] == 0, "R7 error cleared by next read", 64'(v[1]), 64'd0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && !active, "R9 all expected frames seen", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule